// File: doc/BRIEF.md
# CAN bit timing unit

This block turns the system clock into the bit timing of a CAN node. A programmable prescaler divides the clock into time quanta. Each nominal bit is one sync quantum, then a combined propagation-plus-phase-1 segment, then a phase-2 segment. The receive line is sampled once per bit, at the boundary between phase-1 and phase-2. The sampled value goes to a downstream bit-stream processor together with a one-cycle valid strobe. At the first clock of every bit the block also pulses a transmit-update strobe. The transmit side drives its next bit from that pulse.

Falling (recessive-to-dominant) edges on the receive line keep the node in step with the bus. While the bus is idle, such an edge restarts the bit: it causes a hard synchronization. While a frame is in progress, one edge per bit may resynchronize. This lengthens phase-1 or shortens phase-2 by the phase error, limited to the jump width. The processing time after the sample point is zero quanta, so a one-quantum phase-2 is legal. A resync may also cut phase-2 down to nothing.

The sampled-bit output is a valid-only stream. There is no ready input, because bus timing cannot be stalled. The consumer must accept every strobe in the cycle it appears, and a missed strobe is lost. All four timing fields are written as value minus one. The receive line is assumed to be already synchronous to `clk`.

Top module: `can_bit_timer`

## Requirements
- R1: A time quantum lasts `cfg_brp_m1_i`+1 clock cycles. With no receive edges, successive `tx_upd_o` pulses are exactly (1 + (`cfg_ts1_m1_i`+1) + (`cfg_ts2_m1_i`+1)) quanta apart.
- R2: `tx_upd_o` is high for one cycle, in the first clock of every sync segment. This includes sync segments started by a synchronization. In the first cycle after reset it is high, and while reset is held it is high.
- R3: `smp_valid_o` is high for one cycle, at the first clock of phase-2, which is (1 + phase-1 length) quanta after the bit start. `smp_bit_o` then holds the receive-line value from the last clock of phase-1. While reset is held, `smp_valid_o` is 0 and `smp_bit_o` is 1 (recessive).
- R4: A falling edge on `rx_i` is a cycle where `rx_i` is 0 and it was 1 in the cycle before. When this happens with `bus_idle_i` = 1, that cycle becomes the first clock of a new sync segment, with `tx_upd_o` high in it. The next sample point then follows (1 + phase-1) quanta later.
- R5: With `bus_idle_i` = 0, a falling edge in phase-1 quantum q (counted from 0) lengthens phase-1 by min(q+1, jump width) quanta.
- R6: With `bus_idle_i` = 0, a falling edge in phase-2 quantum q has phase error e = phase-2 length − q. If e is at most the jump width, the edge cycle becomes the first clock of a new bit, with `tx_upd_o` high. Otherwise phase-2 is shortened by the jump width.
- R7: A falling edge inside the sync segment changes no timing. Rising edges never change timing.
- R8: At most one resynchronization is applied per bit. A later falling edge in the same bit is ignored.
- R9: The effective jump width is min(`cfg_sjw_m1_i`+1, `cfg_ts1_m1_i`+1) quanta.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Receive line, 1 = recessive, synchronous to clk |
| bus_idle_i | input | 1 | High while no frame is in progress; selects hard synchronization |
| cfg_brp_m1_i | input | BRP_W (6) | Clock cycles per quantum, minus one |
| cfg_ts1_m1_i | input | TS1_W (4) | Propagation-plus-phase-1 quanta, minus one |
| cfg_ts2_m1_i | input | TS2_W (3) | Phase-2 quanta, minus one |
| cfg_sjw_m1_i | input | SJW_W (2) | Jump width quanta, minus one |
| tx_upd_o | output | 1 | Pulse at first clock of each bit |
| smp_valid_o | output | 1 | Valid strobe for the sampled bit (no ready) |
| smp_bit_o | output | 1 | Receive value taken at the sample point |

## Verification
The bench builds the block with its default field widths and changes the timing fields per scenario. Prescalers of one, two, three, four and five clocks are used. A one-clock quantum brings the degenerate case within reach, where each quantum is a single cycle and a one-quantum phase-2 can be cut at the sample point itself. A four-clock quantum with a six-quantum phase-1 lets edges be placed at chosen quantum and clock offsets. This gives lengthening by less than and by the full jump width, partial shortening, restart shortening, a sync-segment edge and a repeated edge. A one-quantum phase-1 against a four-quantum jump field shows the cap on the jump width.

// File: rtl/cbt_pkg.sv
`timescale 1ns/1ps
package cbt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PH1  = 2'd1,
    SEG_PH2  = 2'd2
  } seg_e;
endpackage

// File: rtl/cbt_edge_det.sv
`timescale 1ns/1ps
// Falling-edge finder on the receive line; idle level is recessive (1).
module cbt_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic fall_o
);
  logic rx_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_prev_q <= 1'b1;
    else        rx_prev_q <= rx_i;
  end

  assign fall_o = rx_prev_q & ~rx_i;
endmodule

// File: rtl/cbt_tq_prescaler.sv
`timescale 1ns/1ps
// Clock-to-quantum divider. A restart makes the current cycle the first
// clock of a quantum.
module cbt_tq_prescaler #(
  parameter int BRP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic [BRP_W-1:0] brp_m1_i,
  output logic             q_last_o,
  output logic             cnt_zero_o
);
  logic [BRP_W-1:0] cnt_q, cnt_eff;

  always_comb begin
    cnt_eff  = restart_i ? '0 : cnt_q;
    q_last_o = (cnt_eff == brp_m1_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (q_last_o) cnt_q <= '0;
    else               cnt_q <= cnt_eff + BRP_W'(1);
  end

  assign cnt_zero_o = (cnt_q == '0);
endmodule

// File: rtl/cbt_sync_ctl.sv
`timescale 1ns/1ps
// Decides, for a falling edge, between hard restart, phase-1 stretch,
// phase-2 cut or nothing.
module cbt_sync_ctl
  import cbt_pkg::*;
#(
  parameter int QC_W = 6,
  parameter int JW_W = 3
) (
  input  logic            fall_i,
  input  logic            bus_idle_i,
  input  logic            synced_i,
  input  seg_e            seg_i,
  input  logic [QC_W-1:0] qcnt_i,
  input  logic [QC_W-1:0] ts2_len_i,
  input  logic [QC_W-1:0] sjw_i,
  output logic            restart_o,
  output logic            ext_set_o,
  output logic            cut_set_o,
  output logic            mark_o,
  output logic [JW_W-1:0] adj_o
);
  logic [QC_W-1:0] err_early, err_late;

  always_comb begin
    err_early = qcnt_i + QC_W'(1);
    err_late  = ts2_len_i - qcnt_i;
    restart_o = 1'b0;
    ext_set_o = 1'b0;
    cut_set_o = 1'b0;
    mark_o    = 1'b0;
    adj_o     = '0;
    if (fall_i && bus_idle_i) begin
      restart_o = 1'b1;
    end else if (fall_i && !synced_i) begin
      case (seg_i)
        SEG_PH1: begin
          ext_set_o = 1'b1;
          mark_o    = 1'b1;
          adj_o     = JW_W'((err_early < sjw_i) ? err_early : sjw_i);
        end
        SEG_PH2: begin
          if (err_late <= sjw_i) begin
            restart_o = 1'b1;
          end else begin
            cut_set_o = 1'b1;
            mark_o    = 1'b1;
            adj_o     = JW_W'(sjw_i);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cbt_seg_seq.sv
`timescale 1ns/1ps
// Segment sequencer: walks sync / phase-1 / phase-2 quantum by quantum,
// applies stored adjustments and captures the sample.
module cbt_seg_seq
  import cbt_pkg::*;
#(
  parameter int QC_W = 6,
  parameter int JW_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_i,
  input  logic            q_last_i,
  input  logic            restart_i,
  input  logic            ext_set_i,
  input  logic            cut_set_i,
  input  logic            mark_i,
  input  logic [JW_W-1:0] adj_i,
  input  logic [QC_W-1:0] ts1_len_i,
  input  logic [QC_W-1:0] ts2_len_i,
  output seg_e            seg_o,
  output logic [QC_W-1:0] qcnt_o,
  output logic            synced_o,
  output logic            smp_bit_o
);
  seg_e            seg_q, seg_c, seg_n;
  logic [QC_W-1:0] qcnt_q, qcnt_c, qcnt_n;
  logic [JW_W-1:0] ext_q, ext_c, ext_n;
  logic [JW_W-1:0] cut_q, cut_c, cut_n;
  logic            synced_q, synced_c, synced_n;
  logic            smp_q, smp_n;
  logic [QC_W-1:0] ph1_end, ph2_end;

  always_comb begin
    seg_c    = restart_i ? SEG_SYNC : seg_q;
    qcnt_c   = restart_i ? '0 : qcnt_q;
    ext_c    = restart_i ? '0 : (ext_set_i ? adj_i : ext_q);
    cut_c    = restart_i ? '0 : (cut_set_i ? adj_i : cut_q);
    synced_c = restart_i ? 1'b0 : (synced_q | mark_i);
    ph1_end  = ts1_len_i + QC_W'(ext_c) - QC_W'(1);
    ph2_end  = ts2_len_i - QC_W'(cut_c) - QC_W'(1);

    seg_n    = seg_c;
    qcnt_n   = qcnt_c;
    ext_n    = ext_c;
    cut_n    = cut_c;
    synced_n = synced_c;
    smp_n    = smp_q;

    if (q_last_i) begin
      case (seg_c)
        SEG_SYNC: begin
          seg_n  = SEG_PH1;
          qcnt_n = '0;
        end
        SEG_PH1: begin
          if (qcnt_c == ph1_end) begin
            seg_n  = SEG_PH2;
            qcnt_n = '0;
            smp_n  = rx_i;
          end else begin
            qcnt_n = qcnt_c + QC_W'(1);
          end
        end
        SEG_PH2: begin
          if (qcnt_c == ph2_end) begin
            seg_n    = SEG_SYNC;
            qcnt_n   = '0;
            ext_n    = '0;
            cut_n    = '0;
            synced_n = 1'b0;
          end else begin
            qcnt_n = qcnt_c + QC_W'(1);
          end
        end
        default: begin
          seg_n  = SEG_SYNC;
          qcnt_n = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q    <= SEG_SYNC;
      qcnt_q   <= '0;
      ext_q    <= '0;
      cut_q    <= '0;
      synced_q <= 1'b0;
      smp_q    <= 1'b1;
    end else begin
      seg_q    <= seg_n;
      qcnt_q   <= qcnt_n;
      ext_q    <= ext_n;
      cut_q    <= cut_n;
      synced_q <= synced_n;
      smp_q    <= smp_n;
    end
  end

  assign seg_o     = seg_q;
  assign qcnt_o    = qcnt_q;
  assign synced_o  = synced_q;
  assign smp_bit_o = smp_q;
endmodule

// File: rtl/can_bit_timer.sv
`timescale 1ns/1ps
module can_bit_timer
  import cbt_pkg::*;
#(
  parameter int BRP_W = 6,
  parameter int TS1_W = 4,
  parameter int TS2_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic             bus_idle_i,
  input  logic [BRP_W-1:0] cfg_brp_m1_i,
  input  logic [TS1_W-1:0] cfg_ts1_m1_i,
  input  logic [TS2_W-1:0] cfg_ts2_m1_i,
  input  logic [SJW_W-1:0] cfg_sjw_m1_i,
  output logic             tx_upd_o,
  output logic             smp_valid_o,
  output logic             smp_bit_o
);
  localparam int L1_W = TS1_W + 1;
  localparam int L2_W = TS2_W + 1;
  localparam int QC_W = ((L1_W > L2_W) ? L1_W : L2_W) + 1;
  localparam int JW_W = SJW_W + 1;

  logic [QC_W-1:0] ts1_len, ts2_len, sjw_len, sjw_eff;
  logic            fall_w, restart_w, ext_set_w, cut_set_w, mark_w;
  logic [JW_W-1:0] adj_w;
  logic            q_last_w, cnt_zero_w, synced_w;
  seg_e            seg_w;
  logic [QC_W-1:0] qcnt_w;

  always_comb begin
    ts1_len = QC_W'(cfg_ts1_m1_i) + QC_W'(1);
    ts2_len = QC_W'(cfg_ts2_m1_i) + QC_W'(1);
    sjw_len = QC_W'(cfg_sjw_m1_i) + QC_W'(1);
    sjw_eff = (sjw_len < ts1_len) ? sjw_len : ts1_len;
  end

  cbt_edge_det u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_i   (rx_i),
    .fall_o (fall_w)
  );

  cbt_sync_ctl #(.QC_W(QC_W), .JW_W(JW_W)) u_sync (
    .fall_i     (fall_w),
    .bus_idle_i (bus_idle_i),
    .synced_i   (synced_w),
    .seg_i      (seg_w),
    .qcnt_i     (qcnt_w),
    .ts2_len_i  (ts2_len),
    .sjw_i      (sjw_eff),
    .restart_o  (restart_w),
    .ext_set_o  (ext_set_w),
    .cut_set_o  (cut_set_w),
    .mark_o     (mark_w),
    .adj_o      (adj_w)
  );

  cbt_tq_prescaler #(.BRP_W(BRP_W)) u_presc (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart_i  (restart_w),
    .brp_m1_i   (cfg_brp_m1_i),
    .q_last_o   (q_last_w),
    .cnt_zero_o (cnt_zero_w)
  );

  cbt_seg_seq #(.QC_W(QC_W), .JW_W(JW_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_i       (rx_i),
    .q_last_i   (q_last_w),
    .restart_i  (restart_w),
    .ext_set_i  (ext_set_w),
    .cut_set_i  (cut_set_w),
    .mark_i     (mark_w),
    .adj_i      (adj_w),
    .ts1_len_i  (ts1_len),
    .ts2_len_i  (ts2_len),
    .seg_o      (seg_w),
    .qcnt_o     (qcnt_w),
    .synced_o   (synced_w),
    .smp_bit_o  (smp_bit_o)
  );

  // A restart turns the edge cycle itself into the first sync clock.
  assign tx_upd_o    = ((seg_w == SEG_SYNC) && cnt_zero_w) || restart_w;
  assign smp_valid_o = (seg_w == SEG_PH2) && (qcnt_w == '0) && cnt_zero_w;
endmodule

// File: rtl/cbt_checker.sv
`timescale 1ns/1ps
module cbt_checker
  import cbt_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic rx_i,
  input logic bus_idle_i,
  input logic fall,
  input seg_e seg,
  input logic cnt_zero,
  input logic tx_upd_o,
  input logic smp_valid_o,
  input logic smp_bit_o
);
  // R2: the bit-start pulse never lasts two cycles
  a_r2_tx_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_upd_o |=> !tx_upd_o);

  // R3: the sample strobe never lasts two cycles
  a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_o |=> !smp_valid_o);

  // R3: the delivered bit is the line value of the previous clock
  a_r3_sample_value: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_o |-> (smp_bit_o == $past(rx_i)));

  // R4: an idle-bus falling edge starts a bit in the same cycle
  a_r4_hard_start: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && bus_idle_i) |-> tx_upd_o);

  // R7: an in-frame edge inside the sync segment (after its first clock) does not restart
  a_r7_sync_edge_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !bus_idle_i && (seg == SEG_SYNC) && !cnt_zero) |-> !tx_upd_o);
endmodule

bind can_bit_timer cbt_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_i        (rx_i),
  .bus_idle_i  (bus_idle_i),
  .fall        (fall_w),
  .seg         (seg_w),
  .cnt_zero    (cnt_zero_w),
  .tx_upd_o    (tx_upd_o),
  .smp_valid_o (smp_valid_o),
  .smp_bit_o   (smp_bit_o)
);

// File: tb/can_bit_timer_test.sv
`timescale 1ns/1ps
module can_bit_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       idle = 1'b1;
  logic [5:0] brp_m1 = '0;
  logic [3:0] ts1_m1 = '0;
  logic [2:0] ts2_m1 = '0;
  logic [1:0] sjw_m1 = '0;
  logic       tx_upd, smp_valid, smp_bit;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  can_bit_timer uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_i         (rx),
    .bus_idle_i   (idle),
    .cfg_brp_m1_i (brp_m1),
    .cfg_ts1_m1_i (ts1_m1),
    .cfg_ts2_m1_i (ts2_m1),
    .cfg_sjw_m1_i (sjw_m1),
    .tx_upd_o     (tx_upd),
    .smp_valid_o  (smp_valid),
    .smp_bit_o    (smp_bit)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setup(input int p, input int s1, input int s2, input int j,
                       input logic idl);
    @(negedge clk);
    rst_n  = 1'b0;
    rx     = 1'b1;
    idle   = idl;
    brp_m1 = 6'(p - 1);
    ts1_m1 = 4'(s1 - 1);
    ts2_m1 = 3'(s2 - 1);
    sjw_m1 = 2'(j - 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic next_tx(output int t);
    t = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #1;
      if (tx_upd) begin t = cyc; break; end
    end
  endtask

  task automatic next_smp(output int t, output int b);
    t = -1; b = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #1;
      if (smp_valid) begin t = cyc; b = int'(smp_bit); break; end
    end
  endtask

  task automatic skip(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R1 R2 R3: reset values and an undisturbed bit train
  task automatic t_nominal();
    int t0, t, b;
    @(negedge clk);
    rst_n = 1'b0; rx = 1'b1; idle = 1'b0;
    brp_m1 = 6'd2; ts1_m1 = 4'd4; ts2_m1 = 3'd2; sjw_m1 = 2'd0;
    repeat (2) @(negedge clk);
    #1;
    chk("R3 reset smp_valid", int'(smp_valid), 0);
    chk("R3 reset smp_bit", int'(smp_bit), 1);
    chk("R2 tx_upd held in reset", int'(tx_upd), 1);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R2 tx_upd after reset", int'(tx_upd), 1);
    t0 = cyc;
    next_smp(t, b);
    chk("R3 sample offset", t - t0, 18);
    chk("R3 sample value", b, 1);
    next_tx(t);
    chk("R1 bit length p3", t - t0, 27);
    next_tx(t);
    chk("R1 two bits p3", t - t0, 54);
  endtask

  // R4: hard synchronization while idle
  task automatic t_hard(input int p, input int s1, input int s2, input int off);
    int e, t, b;
    setup(p, s1, s2, 1, 1'b1);
    skip(off);
    rx = 1'b0;
    #1;
    chk("R4 tx_upd at edge", int'(tx_upd), 1);
    e = cyc;
    next_smp(t, b);
    chk("R4 sample after hard sync", t - e, (1 + s1) * p);
    chk("R3 sampled dominant", b, 0);
    next_tx(t);
    chk("R4 bit after hard sync", t - e, (1 + s1 + s2) * p);
    rx = 1'b1;
  endtask

  // R5: phase-1 lengthening (p=4, ph1=6, ph2=3, jump 2)
  task automatic t_lengthen(input int q, input int ext);
    int t0, t, b;
    setup(4, 6, 3, 2, 1'b0);
    next_tx(t0);
    skip((1 + q) * 4 + 2);
    rx = 1'b0;
    next_smp(t, b);
    chk("R5 sample after lengthen", t - t0, (7 + ext) * 4);
    chk("R3 sample value lengthen", b, 0);
    rx = 1'b1;
    next_tx(t);
    chk("R5 bit after lengthen", t - t0, (10 + ext) * 4);
  endtask

  // R6: phase-2 shortened by the jump width
  task automatic t_short_cut();
    int t0, t, b;
    setup(4, 6, 3, 2, 1'b0);
    next_tx(t0);
    next_smp(t, b);
    chk("R3 sample offset p4", t - t0, 28);
    skip(1);
    rx = 1'b0;
    next_tx(t);
    chk("R6 shortened bit", t - t0, 32);
    rx = 1'b1;
  endtask

  // R6: phase error within jump width restarts the bit at the edge
  task automatic t_short_restart();
    int t0, t, b, e;
    setup(4, 6, 3, 2, 1'b0);
    next_tx(t0);
    next_smp(t, b);
    skip(5);
    rx = 1'b0;
    #1;
    chk("R6 restart tx_upd at edge", int'(tx_upd), 1);
    e = cyc;
    chk("R6 edge position", e - t0, 33);
    next_smp(t, b);
    chk("R6 sample after restart", t - e, 28);
    rx = 1'b1;
    next_tx(t);
    chk("R6 bit after restart", t - e, 40);
  endtask

  // R7: sync-segment edge and rising edges leave timing alone
  task automatic t_sync_edge();
    int t0, t, b;
    setup(4, 6, 3, 2, 1'b0);
    next_tx(t0);
    skip(1);
    rx = 1'b0;
    next_smp(t, b);
    chk("R7 sample unchanged", t - t0, 28);
    chk("R7 sample value", b, 0);
    rx = 1'b1;
    next_tx(t);
    chk("R7 bit unchanged", t - t0, 40);
    next_tx(t);
    chk("R7 rising edge ignored", t - t0, 80);
  endtask

  // R8: second falling edge in one bit is ignored
  task automatic t_once();
    int t0, t, b;
    setup(4, 6, 3, 2, 1'b0);
    next_tx(t0);
    skip(5);
    rx = 1'b0;
    skip(2);
    rx = 1'b1;
    skip(10);
    rx = 1'b0;
    next_smp(t, b);
    chk("R8 second edge ignored sample", t - t0, 32);
    rx = 1'b1;
    next_tx(t);
    chk("R8 second edge ignored bit", t - t0, 44);
  endtask

  // R9: jump width capped by phase-1 (p=2, ph1=1, ph2=4, jump field 4)
  task automatic t_cap();
    int t0, t, b;
    setup(2, 1, 4, 4, 1'b0);
    next_tx(t0);
    next_smp(t, b);
    chk("R3 sample offset cap cfg", t - t0, 4);
    skip(1);
    rx = 1'b0;
    next_tx(t);
    chk("R9 capped jump width", t - t0, 10);
    rx = 1'b1;
  endtask

  // R1 R6: one-clock quantum, one-quantum phase-2 cut at the sample point
  task automatic t_min();
    int t0, t, b, e;
    setup(1, 2, 1, 1, 1'b0);
    next_tx(t0);
    next_smp(t, b);
    chk("R3 sample offset p1", t - t0, 3);
    next_tx(t);
    chk("R1 bit length p1", t - t0, 4);
    next_smp(t, b);
    rx = 1'b0;
    #1;
    chk("R6 restart at sample point", int'(tx_upd), 1);
    e = cyc;
    next_smp(t, b);
    chk("R6 sample after p1 restart", t - e, 3);
    chk("R3 sample value p1", b, 0);
    rx = 1'b1;
    next_tx(t);
    chk("R6 bit after p1 restart", t - e, 4);
  endtask

  initial begin
    t_nominal();
    t_hard(2, 4, 2, 5);
    t_hard(1, 2, 1, 2);
    t_hard(5, 3, 2, 7);
    t_lengthen(0, 1);
    t_lengthen(4, 2);
    t_short_cut();
    t_short_restart();
    t_sync_edge();
    t_once();
    t_cap();
    t_min();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule